// File: doc/BRIEF.md
# Serial Frame Aligner with Lock Hysteresis

This block takes a raw serial bit stream whose frame boundaries are unknown and finds them. It looks for a fixed sync word that recurs once per frame. Lock is claimed only after the word has been seen twice, exactly one frame apart. Lock is given up only after a run of consecutive frames in which the word is missing, so a single corrupted frame does not disturb the receiver downstream.

Bits arrive one per cycle, and only on cycles where the valid strobe is high. The first bit that arrives is compared against the most significant bit of the sync word. The block reports three things: whether it is locked, a one-cycle pulse at each frame boundary while it is locked, and the position of the latest bit within the frame. The sync word, the frame length in bits and the miss limit are all parameters.

Top module: `frame_aligner`

## Requirements
- R1: During and right after reset, `locked` is 0, `frame_start` is 0 and `bit_idx` is 0, and the block is hunting.
- R2: While hunting, the block compares the last SYNC_W accepted bits against SYNC_WORD at every bit offset. The oldest bit is compared with the MSB, and the match must be exact. A match moves the block to confirming and sets `bit_idx` to 0 for the bit that completes the word. `locked` stays 0.
- R3: While confirming, if the sync word completes on the accepted bit exactly FRAME_BITS bits after the first hit, `locked` goes to 1 after that bit.
- R4: While confirming, a sync word that completes at any other position is ignored and does not restart `bit_idx`. If the word is absent at the expected position, the block returns to hunting with `locked` at 0.
- R5: While locked, only the bit at which `bit_idx` wraps from FRAME_BITS-1 to 0 is tested. Sync words elsewhere in the frame change neither `bit_idx` nor `locked`.
- R6: While locked, a missing sync word at a boundary leaves `locked` at 1. A sync word at a later boundary clears the count of misses.
- R7: When MISS_LIMIT consecutive boundaries have no sync word, `locked` falls to 0 after the last of them and hunting resumes. Fewer consecutive misses keep `locked` at 1.
- R8: `frame_start` is a one-cycle pulse in the cycle after an accepted boundary bit, whenever `locked` is 1 after that bit. This includes the bit that completes confirmation. It is 0 at all other times.
- R9: `bit_idx` advances by one, modulo FRAME_BITS, for each accepted bit. It is set to 0 only by the bit that starts confirmation.
- R10: A cycle with `bit_vld` low is ignored. `bit_in` is not used, `bit_idx` and `locked` hold, and `frame_start` is 0.
- R11: After reset, no match is declared until at least SYNC_W bits have been accepted. Reset contents of the history never form part of a match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | High when `bit_in` carries a bit |
| locked | output | 1 | High in the locked and loss-check states |
| frame_start | output | 1 | One-cycle pulse after each boundary bit while locked |
| bit_idx | output | $clog2(FRAME_BITS) | Position of the latest accepted bit; 0 is the last bit of the sync word |

## Verification
The main function is driven with frames that carry an all-zero payload and frames that carry an alternating payload. It is also driven with frames in which idle cycles, carrying inverted junk on `bit_in`, are mixed into the bit stream. Comparing the three shows whether acquisition and lock depend on the payload content or on the strobe timing. Other frames carry a misplaced sync word, in the locked state and in the confirming state. These show whether the block tests only the boundary position or re-aligns on any match. A prefix right after reset that would match only with the zeroed history present shows whether a partly filled history is trusted. Miss patterns of miss, hit, miss, miss and then three misses in a row separate a counter that clears on a hit from one that does not, and they mark the exact bit on which lock is dropped.

// File: rtl/frame_aligner_pkg.sv
`timescale 1ns/1ps
// Package: shared types of the frame aligner.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package frame_aligner_pkg;

    // Control states: two unlocked, two locked.
    typedef enum logic [1:0] {
        FA_HUNT    = 2'd0,
        FA_CONFIRM = 2'd1,
        FA_LOCK    = 2'd2,
        FA_LOSS    = 2'd3
    } fa_state_e;

endpackage

// File: rtl/fa_sync_detect.sv
`timescale 1ns/1ps
// Sync word detector.
// Keeps the last SYNC_W-1 accepted bits and compares them, together with
// the incoming bit, against SYNC_WORD. The hit is combinational, in the
// cycle of the completing bit. Assumes SYNC_W >= 2. A fill counter stops
// the reset contents of the history from taking part in a match.
module fa_sync_detect #(
    parameter int                SYNC_W    = 8,
    parameter logic [SYNC_W-1:0] SYNC_WORD = 8'h1D
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_vld,
    output logic hit
);
    localparam int FILL_W = (SYNC_W > 2) ? $clog2(SYNC_W) : 1;
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(SYNC_W - 1);

    logic [SYNC_W-2:0] hist_q;
    logic [SYNC_W-1:0] window;
    logic [FILL_W-1:0] fill_q;
    logic              primed;

    // Candidate window: stored history plus the bit now arriving.
    always_comb begin
        window = {hist_q, bit_in};
        primed = (fill_q == FILL_FULL);
        hit    = bit_vld && primed && (window == SYNC_WORD);
    end

    // History shift register, advanced only on accepted bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (bit_vld) begin
            hist_q <= window[SYNC_W-2:0];
        end
    end

    // Count accepted bits until the history holds SYNC_W-1 real bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (bit_vld && !primed) begin
            fill_q <= fill_q + 1'b1;
        end
    end
endmodule

// File: rtl/fa_frame_counter.sv
`timescale 1ns/1ps
// Bit position counter, modulo FRAME_BITS.
// Position 0 is the last bit of the sync word. `wrap` flags an accepted
// bit that lands on position 0 by normal counting, which is the expected
// boundary. `restart` forces position 0 and is only raised with an
// accepted bit.
module fa_frame_counter #(
    parameter int FRAME_BITS = 32,
    parameter int IDX_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             restart,
    output logic [IDX_W-1:0] idx,
    output logic             wrap
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BITS - 1);

    logic [IDX_W-1:0] idx_q;

    // Boundary flag for the bit now being accepted.
    always_comb begin
        idx  = idx_q;
        wrap = bit_vld && (idx_q == LAST);
    end

    // Advance per accepted bit; restart or wrap return to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (bit_vld) begin
            if (restart || wrap) begin
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fa_lock_fsm.sv
`timescale 1ns/1ps
// Lock control machine with hysteresis.
// Hunts on every bit, confirms on one boundary, then tests only the
// boundaries. It drops lock after MISS_LIMIT consecutive misses.
// Assumes MISS_LIMIT >= 2. The first miss is counted by entering the
// loss-check state, and miss_q counts the misses after it.
module fa_lock_fsm
    import frame_aligner_pkg::*;
#(
    parameter int MISS_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic wrap,
    output logic restart,
    output logic locked,
    output logic frame_start
);
    localparam int MISS_W = (MISS_LIMIT > 2) ? $clog2(MISS_LIMIT - 1) : 1;
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_LIMIT - 2);

    fa_state_e         state_q, state_d;
    logic [MISS_W-1:0] miss_q, miss_d;
    logic              fs_q, fs_d;

    // Next state, miss count and boundary pulse.
    always_comb begin
        state_d = state_q;
        miss_d  = miss_q;
        restart = 1'b0;
        unique case (state_q)
            FA_HUNT: begin
                if (hit) begin
                    state_d = FA_CONFIRM;
                    restart = 1'b1;
                end
            end
            FA_CONFIRM: begin
                if (wrap) begin
                    state_d = hit ? FA_LOCK : FA_HUNT;
                end
            end
            FA_LOCK: begin
                if (wrap && !hit) begin
                    state_d = FA_LOSS;
                    miss_d  = '0;
                end
            end
            FA_LOSS: begin
                if (wrap) begin
                    if (hit) begin
                        state_d = FA_LOCK;
                        miss_d  = '0;
                    end else if (miss_q == MISS_LAST) begin
                        state_d = FA_HUNT;
                    end else begin
                        miss_d = miss_q + 1'b1;
                    end
                end
            end
            default: state_d = FA_HUNT;
        endcase
        fs_d = wrap && ((state_d == FA_LOCK) || (state_d == FA_LOSS));
    end

    // State, miss counter and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FA_HUNT;
            miss_q  <= '0;
            fs_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            miss_q  <= miss_d;
            fs_q    <= fs_d;
        end
    end

    // Lock status covers both locked sub-states.
    always_comb begin
        locked      = (state_q == FA_LOCK) || (state_q == FA_LOSS);
        frame_start = fs_q;
    end
endmodule

// File: rtl/frame_aligner.sv
`timescale 1ns/1ps
// Serial frame aligner, top level.
// Connects the sync detector, the bit position counter and the lock
// machine. It assumes one bit per accepted cycle, SYNC_W >= 2,
// FRAME_BITS > SYNC_W and MISS_LIMIT >= 2.
module frame_aligner #(
    parameter int                SYNC_W     = 8,
    parameter logic [SYNC_W-1:0] SYNC_WORD  = 8'h1D,
    parameter int                FRAME_BITS = 32,
    parameter int                MISS_LIMIT = 3,
    localparam int               IDX_W      = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             bit_vld,
    output logic             locked,
    output logic             frame_start,
    output logic [IDX_W-1:0] bit_idx
);
    logic hit;
    logic wrap;
    logic restart;

    fa_sync_detect #(
        .SYNC_W    (SYNC_W),
        .SYNC_WORD (SYNC_WORD)
    ) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (bit_in),
        .bit_vld (bit_vld),
        .hit     (hit)
    );

    fa_frame_counter #(
        .FRAME_BITS (FRAME_BITS),
        .IDX_W      (IDX_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_vld (bit_vld),
        .restart (restart),
        .idx     (bit_idx),
        .wrap    (wrap)
    );

    fa_lock_fsm #(
        .MISS_LIMIT (MISS_LIMIT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hit),
        .wrap        (wrap),
        .restart     (restart),
        .locked      (locked),
        .frame_start (frame_start)
    );
endmodule

// File: rtl/frame_aligner_chk.sv
`timescale 1ns/1ps
// Checker for the frame aligner, attached by bind.
// Relates only the block's ports over time.
module frame_aligner_chk #(
    parameter int FRAME_BITS = 32,
    parameter int IDX_W      = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_vld,
    input logic             locked,
    input logic             frame_start,
    input logic [IDX_W-1:0] bit_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BITS - 1);

    // R8
    fs_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (locked && (bit_idx == '0)));

    // R8
    fs_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> (!frame_start && $stable(bit_idx) && $stable(locked)));

    // R9
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> ((bit_idx == '0) || (bit_idx == $past(bit_idx) + 1'b1)));

    // R3
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (frame_start && (bit_idx == '0)));

    // R7
    lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> ($past(bit_vld) && ($past(bit_idx) == LAST)));
endmodule

bind frame_aligner frame_aligner_chk #(
    .FRAME_BITS (FRAME_BITS),
    .IDX_W      (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_vld     (bit_vld),
    .locked      (locked),
    .frame_start (frame_start),
    .bit_idx     (bit_idx)
);

// File: tb/test_frame_aligner.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver runs a behavioural model per cycle and
// queues the expected outputs; the monitor compares on falling edges.
module test_frame_aligner;
    localparam int          CLK_PERIOD = 10;
    localparam int          SW         = 8;
    localparam logic [7:0]  SYNC       = 8'h1D;
    localparam int          FB         = 32;
    localparam int          ML         = 3;
    localparam int          IW         = $clog2(FB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_in = 1'b0;
    logic          bit_vld = 1'b0;
    logic          locked;
    logic          frame_start;
    logic [IW-1:0] bit_idx;

    int n_chk = 0;
    int n_bad = 0;

    logic  q_lk[$];
    logic  q_fs[$];
    int    q_idx[$];
    string q_req[$];
    string cur_req = "R1";
    bit    gap_mode = 0;
    int    gap_ctr = 0;

    // Reference model state
    logic [7:0] m_hist = '0;
    int m_cnt = 0, m_st = 0, m_idx = 0, m_miss = 0;
    logic m_fs = 0;

    frame_aligner #(
        .SYNC_W(SW), .SYNC_WORD(SYNC), .FRAME_BITS(FB), .MISS_LIMIT(ML)
    ) i_frame_aligner (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .locked(locked), .frame_start(frame_start), .bit_idx(bit_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model step for one clock: 0 hunt, 1 confirm, 2 lock, 3 loss-check.
    task automatic model_step(input logic vld, input logic b);
        logic hitm, wrapm;
        m_fs = 1'b0;
        if (vld) begin
            hitm  = (m_cnt >= SW - 1) && ({m_hist[SW-2:0], b} == SYNC);
            m_hist = {m_hist[SW-2:0], b};
            if (m_cnt < SW - 1) m_cnt++;
            wrapm = (m_idx == FB - 1);
            m_idx = (m_idx + 1) % FB;
            case (m_st)
                0: if (hitm) begin m_st = 1; m_idx = 0; end
                1: if (wrapm) m_st = hitm ? 2 : 0;
                2: if (wrapm && !hitm) begin m_st = 3; m_miss = 1; end
                default: if (wrapm) begin
                    if (hitm) m_st = 2;
                    else begin
                        m_miss++;
                        if (m_miss >= ML) m_st = 0;
                    end
                end
            endcase
            m_fs = wrapm && (m_st >= 2);
        end
        q_lk.push_back(m_st >= 2);
        q_fs.push_back(m_fs);
        q_idx.push_back(m_idx);
        q_req.push_back(cur_req);
    endtask

    // Driver: one accepted bit, optionally preceded by an idle junk cycle.
    task automatic send_bit(input logic b);
        if (gap_mode && (gap_ctr % 3 == 0)) begin
            bit_vld = 1'b0; bit_in = ~b;
            @(posedge clk); #1;
            model_step(1'b0, ~b);
        end
        gap_ctr++;
        bit_vld = 1'b1; bit_in = b;
        @(posedge clk); #1;
        model_step(1'b1, b);
        bit_vld = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    // kind 0: zero payload, 1: alternating payload, 2: payload with a
    // misplaced sync word. with_sync selects the sync word or zeros.
    task automatic send_frame(input int kind, input bit with_sync);
        for (int i = 0; i < FB - SW; i++) begin
            if (kind == 1) send_bit(logic'(i % 2));
            else if (kind == 2 && i >= 8 && i < 16) send_bit(SYNC[15 - i]);
            else send_bit(1'b0);
        end
        if (with_sync) send_bits({24'd0, SYNC}, SW);
        else send_zeros(SW);
    endtask

    // Monitor: compare the expected item for the last edge.
    always @(negedge clk) begin
        if (rst_n && q_lk.size() > 0) begin
            logic  elk, efs;
            int    eidx;
            string r;
            elk = q_lk.pop_front(); efs = q_fs.pop_front();
            eidx = q_idx.pop_front(); r = q_req.pop_front();
            n_chk++;
            if (locked !== elk || frame_start !== efs || int'(bit_idx) != eidx) begin
                n_bad++;
                $display("FAIL %s: locked/frame_start/bit_idx = %0b/%0b/%0d, expected %0b/%0b/%0d",
                         r, locked, frame_start, bit_idx, elk, efs, eidx);
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        n_chk++;
        if (locked !== 1'b0 || frame_start !== 1'b0 || bit_idx !== '0) begin
            n_bad++;
            $display("FAIL R1: locked/frame_start/bit_idx = %0b/%0b/%0d, expected 0/0/0",
                     locked, frame_start, bit_idx);
        end
        rst_n = 1'b1;

        // R11: a prefix that matches only with zeroed history must not hit
        cur_req = "R11";
        send_bits(32'b11101, 5);
        send_zeros(10);
        // R2: first hit restarts the position
        cur_req = "R2";
        send_zeros(3);
        send_bits({24'd0, SYNC}, SW);
        // R3: confirmation one frame later gives lock
        cur_req = "R3";
        send_frame(0, 1);
        // R8 / R9: locked frames with an alternating payload
        cur_req = "R8";
        send_frame(1, 1);
        cur_req = "R9";
        send_frame(0, 1);
        // R10: idle cycles with junk on the data input
        cur_req = "R10";
        gap_mode = 1;
        send_frame(1, 1);
        send_frame(0, 1);
        gap_mode = 0;
        // R5: misplaced sync word while locked
        cur_req = "R5";
        send_frame(2, 1);
        // R6: miss, hit, miss, miss, hit keeps lock
        cur_req = "R6";
        send_frame(0, 0);
        send_frame(0, 1);
        send_frame(0, 0);
        send_frame(1, 0);
        send_frame(0, 1);
        // R7: three consecutive misses drop lock
        cur_req = "R7";
        send_frame(0, 0);
        send_frame(0, 0);
        send_frame(0, 0);
        send_zeros(5);
        // R4: misplaced word while confirming, then a miss at the boundary
        cur_req = "R4";
        send_bits({24'd0, SYNC}, SW);
        send_zeros(10);
        send_bits({24'd0, SYNC}, SW);
        send_zeros(14);
        send_zeros(6);
        // R2: reacquire at a new alignment
        cur_req = "R2";
        send_bits({24'd0, SYNC}, SW);
        send_frame(1, 1);
        send_frame(0, 1);
        send_zeros(4);

        @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule